// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits between a large set of peripheral interrupt lines and a CPU core. It reduces all of them to one interrupt request and names the source that should be served. Two kinds of source feed it. A small group of trap lines cannot be masked. A larger group of maskable lines each have an enable bit and a programmable priority level. For the winning source the block presents a vector number and the program-memory word address of that source's entry in the vector table. The CPU reads the handler address from that entry. Reading the entry is done outside this block.

Arbitration works in two tiers. Any pending trap beats every maskable source, and among traps the lowest index wins. Among maskable sources that pass the mask, the highest programmed level wins, and a tie goes to the lowest vector index. A single table-select input moves every lookup, traps included, from the primary table to an alternate table that directly follows it. The chosen vector is captured in a register and held until the CPU acknowledges it.

Top module: `prio_vec_intc`

## Requirements
- R1: While reset is asserted and right after it, `cpu_irq` is 0 and `vec_num` and `vec_addr` are 0. No request seen during reset is presented.
- R2: A pending trap beats every maskable source. Among traps the lowest index wins. Trap t has vector number t (0..N_TRAP-1).
- R3: Maskable source i has vector number N_TRAP+i. It can win only when three things hold: its enable bit is 1, its level field (`irq_lvl[3*i +: 3]`) is nonzero, and that level is strictly greater than `cpu_lvl`. Level 0 or a cleared enable removes the source from arbitration.
- R4: Among eligible maskable sources the highest level wins. On equal levels the lower vector number wins.
- R5: `vec_addr` = base + 2 × `vec_num`. The base is 0x000004 when `alt_tbl` is 0 at capture. It is 0x000004 + 2 × 126 = 0x000100 when `alt_tbl` is 1 at capture.
- R6: A request that is present before clock edge k is presented on `cpu_irq`, `vec_num` and `vec_addr` after edge k+1. The latency is a fixed two edges.
- R7: While `cpu_irq` is 1 and `cpu_ack` is 0, `vec_num` and `vec_addr` hold. This is true even when a stronger source or a trap arrives, or when `alt_tbl` changes.
- R8: `cpu_ack` with `cpu_irq` high drops `cpu_irq` at the next edge. It also clears the served source's pending flag for one cycle. Another pending source is therefore presented one edge later, and the served source may win again after that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | N_TRAP | Non-maskable trap request lines |
| irq_req | input | N_IRQ | Maskable interrupt request lines |
| irq_en | input | N_IRQ | Per-source enable |
| irq_lvl | input | N_IRQ*LVL_W | Per-source level, source i at bits [LVL_W*i +: LVL_W] |
| cpu_lvl | input | LVL_W | Current CPU priority level |
| alt_tbl | input | 1 | 1 selects the alternate vector table |
| cpu_ack | input | 1 | CPU accepts the presented vector |
| cpu_irq | output | 1 | Interrupt request toward the CPU |
| vec_num | output | VEC_W | Winning vector number |
| vec_addr | output | PC_W | Program-memory address of the winning vector entry |

## Verification
Each request is registered once into a pending flag and once into the output register. The bench therefore drives inputs at a falling edge and reads results at the falling edge after the second rising edge. For R6 it also confirms that nothing is visible after only one edge. After an acknowledge, the bench expects `cpu_irq` low after one edge and the next winner after two, and it samples in those exact cycles. Hold behaviour is checked by changing requests and `alt_tbl` while a vector is presented, then reading the outputs several cycles later.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int PC_W = 24;
  typedef logic [PC_W-1:0] pc_t;

  // entry address: base, plus a whole table when the alternate one is used, plus two words per vector
  function automatic pc_t entry_addr(pc_t base, int unsigned n_vec, logic alt, int unsigned vec);
    pc_t off;
    off = pc_t'(2 * vec);
    if (alt) off = off + pc_t'(2 * n_vec);
    return base + off;
  endfunction
endpackage

// File: rtl/ivc_trap_pick.sv
module ivc_trap_pick #(
  parameter int N_TRAP = 8,
  parameter int IDX_W  = 7
) (
  input  logic [N_TRAP-1:0] pend,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int t = N_TRAP - 1; t >= 0; t--) begin
      if (pend[t]) begin
        hit = 1'b1;
        idx = IDX_W'(t);
      end
    end
  end
endmodule

// File: rtl/ivc_lvl_arb.sv
module ivc_lvl_arb #(
  parameter int N_IRQ = 118,
  parameter int LVL_W = 3,
  parameter int SRC_W = 7
) (
  input  logic [N_IRQ-1:0]       pend,
  input  logic [N_IRQ-1:0]       en,
  input  logic [N_IRQ*LVL_W-1:0] lvl,
  input  logic [LVL_W-1:0]       cpu_lvl,
  output logic                   hit,
  output logic [SRC_W-1:0]       idx,
  output logic [LVL_W-1:0]       win_lvl
);
  logic [LVL_W-1:0] lvl_a [N_IRQ];
  logic [N_IRQ-1:0] elig;

  genvar g;
  generate
    for (g = 0; g < N_IRQ; g++) begin : g_src
      assign lvl_a[g] = lvl[g*LVL_W +: LVL_W];
      // level 0 never exceeds cpu_lvl, so it is masked by the same compare
      assign elig[g]  = pend[g] && en[g] && (lvl_a[g] > cpu_lvl);
    end
  endgenerate

  // strict greater-than keeps the lowest index on ties
  always_comb begin
    hit     = 1'b0;
    idx     = '0;
    win_lvl = '0;
    for (int i = 0; i < N_IRQ; i++) begin
      if (elig[i] && (lvl_a[i] > win_lvl)) begin
        hit     = 1'b1;
        idx     = SRC_W'(i);
        win_lvl = lvl_a[i];
      end
    end
  end
endmodule

// File: rtl/ivc_vec_hold.sv
module ivc_vec_hold #(
  parameter int VEC_W = 7,
  parameter int PC_W  = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             take,
  input  logic [VEC_W-1:0] d_vec,
  input  logic [PC_W-1:0]  d_addr,
  output logic             valid,
  output logic [VEC_W-1:0] q_vec,
  output logic [PC_W-1:0]  q_addr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      q_vec  <= '0;
      q_addr <= '0;
    end else if (take) begin
      valid <= 1'b0;
    end else if (load) begin
      valid  <= 1'b1;
      q_vec  <= d_vec;
      q_addr <= d_addr;
    end
  end
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
  import intc_pkg::*;
#(
  parameter int  N_TRAP   = 8,
  parameter int  N_IRQ    = 118,
  parameter int  LVL_W    = 3,
  parameter pc_t PRI_BASE = 24'h000004,
  localparam int N_VEC    = N_TRAP + N_IRQ,
  localparam int VEC_W    = $clog2(N_VEC),
  localparam int SRC_W    = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_TRAP-1:0]      trap_req,
  input  logic [N_IRQ-1:0]       irq_req,
  input  logic [N_IRQ-1:0]       irq_en,
  input  logic [N_IRQ*LVL_W-1:0] irq_lvl,
  input  logic [LVL_W-1:0]       cpu_lvl,
  input  logic                   alt_tbl,
  input  logic                   cpu_ack,
  output logic                   cpu_irq,
  output logic [VEC_W-1:0]       vec_num,
  output logic [PC_W-1:0]        vec_addr
);
  logic [N_TRAP-1:0] trap_pend_q, trap_clr;
  logic [N_IRQ-1:0]  irq_pend_q, irq_clr;
  logic              trap_hit, irq_hit, load_evt, ack_take;
  logic [VEC_W-1:0]  trap_idx, win_vec;
  logic [SRC_W-1:0]  irq_idx;
  logic [LVL_W-1:0]  win_lvl;
  pc_t               win_addr;

  assign ack_take = cpu_ack && cpu_irq;

  genvar g;
  generate
    for (g = 0; g < N_TRAP; g++) begin : g_tclr
      assign trap_clr[g] = ack_take && (vec_num == VEC_W'(g));
    end
    for (g = 0; g < N_IRQ; g++) begin : g_iclr
      assign irq_clr[g] = ack_take && (vec_num == VEC_W'(N_TRAP + g));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trap_pend_q <= '0;
      irq_pend_q  <= '0;
    end else begin
      trap_pend_q <= trap_req & ~trap_clr;
      irq_pend_q  <= irq_req & ~irq_clr;
    end
  end

  ivc_trap_pick #(.N_TRAP(N_TRAP), .IDX_W(VEC_W)) u_trap (
    .pend(trap_pend_q), .hit(trap_hit), .idx(trap_idx)
  );

  ivc_lvl_arb #(.N_IRQ(N_IRQ), .LVL_W(LVL_W), .SRC_W(SRC_W)) u_arb (
    .pend(irq_pend_q), .en(irq_en), .lvl(irq_lvl), .cpu_lvl(cpu_lvl),
    .hit(irq_hit), .idx(irq_idx), .win_lvl(win_lvl)
  );

  assign win_vec  = trap_hit ? trap_idx : VEC_W'(N_TRAP) + VEC_W'(irq_idx);
  assign win_addr = entry_addr(PRI_BASE, N_VEC, alt_tbl, 32'(win_vec));
  assign load_evt = !cpu_irq && (trap_hit || irq_hit);

  ivc_vec_hold #(.VEC_W(VEC_W), .PC_W(PC_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(load_evt), .take(ack_take),
    .d_vec(win_vec), .d_addr(win_addr),
    .valid(cpu_irq), .q_vec(vec_num), .q_addr(vec_addr)
  );
endmodule

// File: rtl/prio_vec_intc_chk.sv
module prio_vec_intc_chk
  import intc_pkg::*;
#(
  parameter int  N_TRAP   = 8,
  parameter int  N_VEC    = 126,
  parameter int  LVL_W    = 3,
  parameter int  VEC_W    = 7,
  parameter pc_t PRI_BASE = 24'h000004
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_irq,
  input logic             cpu_ack,
  input logic [VEC_W-1:0] vec_num,
  input logic [PC_W-1:0]  vec_addr,
  input logic [LVL_W-1:0] cpu_lvl,
  input logic             load_evt,
  input logic             trap_hit,
  input logic [LVL_W-1:0] win_lvl
);
  localparam logic [VEC_W-1:0] TRAP_LIM = VEC_W'(N_TRAP);
  localparam pc_t              ADDR_LIM = pc_t'(PRI_BASE + pc_t'(4 * N_VEC));

  AST_TRAP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt && trap_hit |=> vec_num < TRAP_LIM); // R2
  AST_ABOVE_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt && !trap_hit |-> win_lvl > cpu_lvl); // R3
  AST_ADDR_IN_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> vec_addr >= PRI_BASE && vec_addr < ADDR_LIM && vec_addr[0] == PRI_BASE[0]); // R5
  AST_LOAD_PRESENTS: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> cpu_irq); // R6
  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq && !cpu_ack |=> cpu_irq && $stable(vec_num) && $stable(vec_addr)); // R7
  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq && cpu_ack |=> !cpu_irq); // R8
endmodule

bind prio_vec_intc prio_vec_intc_chk #(
  .N_TRAP(N_TRAP), .N_VEC(N_VEC), .LVL_W(LVL_W), .VEC_W(VEC_W), .PRI_BASE(PRI_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_irq(cpu_irq), .cpu_ack(cpu_ack),
  .vec_num(vec_num), .vec_addr(vec_addr), .cpu_lvl(cpu_lvl),
  .load_evt(load_evt), .trap_hit(trap_hit), .win_lvl(win_lvl)
);

// File: tb/sim_prio_vec_intc.sv
`timescale 1ns/1ps
module sim_prio_vec_intc;
  localparam int NT = 8;
  localparam int NI = 118;
  localparam int NONE = 127;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NT-1:0] trap_req = '0;
  logic [NI-1:0] irq_req = '0;
  logic [NI-1:0] irq_en = '0;
  logic [NI*3-1:0] irq_lvl = '0;
  logic [2:0]    cpu_lvl = '0;
  logic          alt_tbl = 1'b0;
  logic          cpu_ack = 1'b0;
  logic          cpu_irq;
  logic [6:0]    vec_num;
  logic [23:0]   vec_addr;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  prio_vec_intc u0 (
    .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .irq_req(irq_req),
    .irq_en(irq_en), .irq_lvl(irq_lvl), .cpu_lvl(cpu_lvl), .alt_tbl(alt_tbl),
    .cpu_ack(cpu_ack), .cpu_irq(cpu_irq), .vec_num(vec_num), .vec_addr(vec_addr)
  );

  // entry layout: trap[39:32] ia[31:25] la[24:22] ea[21] ib[20:14] lb[13:11] cpu[10:8] alt[7] exp[6:0]
  function automatic logic [39:0] mk(int tr, int ia, int la, int ea, int ib, int lb,
                                     int cl, int al, int ex);
    return {8'(tr), 7'(ia), 3'(la), 1'(ea), 7'(ib), 3'(lb), 3'(cl), 1'(al), 7'(ex)};
  endfunction

  localparam int NV = 11;
  localparam logic [39:0] TBL [NV] = '{
    mk(0,    3, 5, 1, 10, 5, 0, 0, 11),   // R4 tie -> lower index
    mk(0,    3, 2, 1, 10, 6, 0, 0, 18),   // R4 higher level
    mk(0,    3, 7, 0, 10, 1, 0, 0, 18),   // R3 disabled ignored
    mk(0,    3, 0, 1, 10, 0, 0, 0, NONE), // R3 level 0
    mk(0,    3, 4, 1, 10, 5, 4, 0, 18),   // R3 above cpu
    mk(0,    3, 4, 1, 10, 5, 5, 0, NONE), // R3 equal to cpu masked
    mk(8'h24, 3, 7, 1, 10, 7, 0, 0, 2),   // R2 lowest trap
    mk(8'h80, 3, 7, 1, 10, 7, 0, 1, 7),   // R2 trap over level 7, R5 alt
    mk(0,  117, 1, 1,  0, 1, 0, 1, 8),    // R4 tie at ends, R5 alt
    mk(0,  117, 3, 1,  0, 2, 0, 1, 125),  // R5 last vector alt
    mk(0,    5, 7, 1,  6, 7, 7, 0, NONE)  // R3 cpu at 7 blocks all
  };

  function automatic logic [23:0] exp_addr(int v, logic alt);
    return alt ? 24'(256 + 2 * v) : 24'(4 + 2 * v);
  endfunction

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_src(int i, int l, logic e);
    irq_req[i] = 1'b1;
    irq_en[i]  = e;
    irq_lvl[i*3 +: 3] = 3'(l);
  endtask

  task automatic wipe();
    trap_req = '0; irq_req = '0; irq_en = '0; irq_lvl = '0;
    cpu_lvl = '0; alt_tbl = 1'b0;
  endtask

  task automatic serve_and_clear();
    cpu_ack = 1'b1;
    wipe();
    tick();
    cpu_ack = 1'b0;
    tick();
    tick();
  endtask

  initial begin
    // R1: reset with a trap pending
    trap_req = 8'h01;
    tick(); tick();
    chk("R1 irq in reset", int'(cpu_irq), 0);
    chk("R1 vec in reset", int'(vec_num), 0);
    chk("R1 addr in reset", int'(vec_addr), 0);
    trap_req = '0;
    tick();
    rst_n = 1'b1;
    tick(); tick();
    chk("R1 irq after reset", int'(cpu_irq), 0);

    // table walk
    for (int k = 0; k < NV; k++) begin
      logic [39:0] e;
      e = TBL[k];
      trap_req = e[39:32];
      set_src(int'(e[31:25]), int'(e[24:22]), e[21]);
      set_src(int'(e[20:14]), int'(e[13:11]), 1'b1);
      cpu_lvl = e[10:8];
      alt_tbl = e[7];
      tick(); tick();
      if (int'(e[6:0]) == NONE) begin
        tick();
        chk($sformatf("R3 row%0d no irq", k), int'(cpu_irq), 0);
      end else begin
        chk($sformatf("R2/R4 row%0d irq", k), int'(cpu_irq), 1);
        chk($sformatf("R2/R4 row%0d vec", k), int'(vec_num), int'(e[6:0]));
        chk($sformatf("R5 row%0d addr", k), int'(vec_addr), int'(exp_addr(int'(e[6:0]), e[7])));
      end
      serve_and_clear();
    end

    // R6: latency of two edges
    set_src(20, 2, 1'b1);
    tick();
    chk("R6 not yet after one edge", int'(cpu_irq), 0);
    tick();
    chk("R6 irq after two edges", int'(cpu_irq), 1);
    chk("R6 vec", int'(vec_num), 28);
    serve_and_clear();

    // R7: hold while unacknowledged
    set_src(10, 3, 1'b1);
    tick(); tick();
    chk("R7 first vec", int'(vec_num), 18);
    trap_req[0] = 1'b1;
    alt_tbl = 1'b1;
    set_src(3, 7, 1'b1);
    tick(); tick(); tick();
    chk("R7 still irq", int'(cpu_irq), 1);
    chk("R7 vec held", int'(vec_num), 18);
    chk("R7 addr held", int'(vec_addr), 24'h28);
    cpu_ack = 1'b1;
    tick();
    cpu_ack = 1'b0;
    chk("R8 drop after ack", int'(cpu_irq), 0);
    tick();
    chk("R2 trap after ack", int'(vec_num), 0);
    chk("R5 trap alt addr", int'(vec_addr), 24'h100);
    serve_and_clear();

    // R8: acked source yields one cycle to an equal-level peer
    set_src(3, 6, 1'b1);
    set_src(10, 6, 1'b1);
    tick(); tick();
    chk("R8 first winner", int'(vec_num), 11);
    chk("R5 first addr", int'(vec_addr), 24'h1A);
    cpu_ack = 1'b1;
    tick();
    cpu_ack = 1'b0;
    chk("R8 irq low after ack", int'(cpu_irq), 0);
    tick();
    chk("R8 peer presented", int'(cpu_irq), 1);
    chk("R8 peer vec", int'(vec_num), 18);
    cpu_ack = 1'b1;
    tick();
    cpu_ack = 1'b0;
    tick();
    chk("R8 first source again", int'(vec_num), 11);
    serve_and_clear();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog expired got=running exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule